// File: doc/BRIEF.md
# Message and Level Interrupt Source Unit

This unit holds the state of a fixed set of interrupt sources and turns their activity into offers toward an interrupt presenter. Each source is either a message type, where every cycle with its trigger input high counts as one event, or a level type, where the trigger input is a level that the unit follows. For every source the unit stores a target server and an 8-bit priority. The priority value 0xFF means the source is masked. Each source also has four status flags: asserted, sent, rejected and masked-pending.

An offer carries a global source number, the priority and the server. The global number is the local index plus a base offset. The presenter answers with reject or end-of-interrupt (EOI) numbers in the same global numbering. It can also ask for a resend scan. The scan walks through all sources, one per cycle, and retries the ones that were turned away. Offers leave the unit one at a time over a valid/ready handshake, lowest local index first. A source whose offer is waiting stays queued until the handshake completes.

When several events reach the same source in one cycle, they are applied in this order: handshake completion, level sample, reject, EOI, configuration write, trigger, masked-pending release, scan visit.

Top module: `irq_source_unit`

## Requirements
- R1: After reset every source has priority 0xFF, server 0, and all status cleared. No offer is valid and no scan is busy.
- R2: A message trigger on an unmasked source queues an offer. The offer shows number SRC_BASE+index, the source's priority and its server on the cycle after the trigger.
- R3: A message trigger on a masked source sets masked-pending and produces no offer. A later configuration write with a priority other than 0xFF clears masked-pending and queues the offer.
- R4: A level source copies its input into the asserted flag every cycle. It is checked when its input changes, when it is configured, or when the scan visits it. If at that check it is unmasked, asserted and not sent, it sets sent and queues one offer. While sent stays set, it queues no further offers.
- R5: A reject sets the rejected flag of a message source and clears sent on a level source. Neither is re-offered until a scan visits it or, for a level source, until its input changes or it is configured.
- R6: An EOI clears sent on a level source, so the next scan re-offers it if it is still asserted. An EOI to a message source changes nothing.
- R7: A resend request while idle starts a scan. The scan is busy for exactly NUM_SRC cycles and visits indices 0 to NUM_SRC-1 in order. At its visit, a rejected message source has rejected cleared and is queued if unmasked. A request made while a scan is busy is ignored.
- R8: At most one offer is valid at a time, always for the lowest queued index. It stays valid until offer_ready is high at a clock edge, and that edge dequeues it.
- R9: Reject and EOI numbers outside SRC_BASE to SRC_BASE+NUM_SRC-1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Per-source type: 1 = level, 0 = message |
| trig_in | input | NUM_SRC | Message event pulse or level input per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SERVER_W | Target server written |
| cfg_prio | input | 8 | Priority written (0xFF masks) |
| rej_valid | input | 1 | Reject return strobe |
| rej_num | input | SRCNUM_W | Global number rejected |
| eoi_valid | input | 1 | EOI return strobe |
| eoi_num | input | SRCNUM_W | Global number of the EOI |
| resend_req | input | 1 | Start a resend scan |
| resend_busy | output | 1 | Scan in progress |
| offer_valid | output | 1 | Offer present |
| offer_ready | input | 1 | Presenter takes the offer |
| offer_num | output | SRCNUM_W | Global source number offered |
| offer_prio | output | 8 | Priority offered |
| offer_server | output | SERVER_W | Server offered |

## Verification
The hardest case to reach from the ports is the retry path. A reject or EOI must land on a source that has already been offered and dequeued. The stale state must then stay silent, and only a later scan may bring the source back out. Reaching this needs configuration, a trigger, a completed handshake, a reject or EOI, and then a scan, in that order. Directed sequences build that chain for one message and one level source, including an out-of-range return in between. A long pseudo-random phase then mixes pulses, level toggles, writes, returns, scans and a stalling ready against a cycle-by-cycle reference model. That phase also produces same-cycle collisions on one source.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

    localparam int PRIO_W = 8;
    localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
        logic queued;
    } src_status_t;

    function automatic logic prio_live(prio_t p);
        return p != PRIO_OFF;
    endfunction

endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
    import irqsrc_pkg::*;
#(
    parameter int SERVER_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                is_level,
    input  logic                trig,
    input  logic                cfg_hit,
    input  logic [SERVER_W-1:0] cfg_server,
    input  prio_t               cfg_prio,
    input  logic                rej_hit,
    input  logic                eoi_hit,
    input  logic                scan_hit,
    input  logic                grant,
    output logic                queued,
    output prio_t               prio,
    output logic [SERVER_W-1:0] server
);

    src_status_t         st_q, st_d;
    prio_t               prio_q, prio_d;
    logic [SERVER_W-1:0] server_q, server_d;
    logic                lvl_change;

    assign lvl_change = trig != st_q.asserted;

    always_comb begin
        st_d     = st_q;
        prio_d   = prio_q;
        server_d = server_q;
        if (grant) st_d.queued = 1'b0;
        if (is_level) st_d.asserted = trig;
        if (rej_hit) begin
            if (is_level) st_d.sent = 1'b0;
            else          st_d.rejected = 1'b1;
        end
        if (eoi_hit && is_level) st_d.sent = 1'b0;
        if (cfg_hit) begin
            prio_d   = cfg_prio;
            server_d = cfg_server;
        end
        if (!is_level) begin
            if (trig) begin
                if (prio_live(prio_d)) st_d.queued = 1'b1;
                else                   st_d.mpend  = 1'b1;
            end
            if (cfg_hit && st_d.mpend && prio_live(prio_d)) begin
                st_d.mpend  = 1'b0;
                st_d.queued = 1'b1;
            end
            if (scan_hit && st_d.rejected) begin
                st_d.rejected = 1'b0;
                if (prio_live(prio_d)) st_d.queued = 1'b1;
            end
        end else begin
            if ((cfg_hit || scan_hit || lvl_change) && prio_live(prio_d)
                && st_d.asserted && !st_d.sent) begin
                st_d.sent   = 1'b1;
                st_d.queued = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= '0;
            prio_q   <= PRIO_OFF;
            server_q <= '0;
        end else begin
            st_q     <= st_d;
            prio_q   <= prio_d;
            server_q <= server_d;
        end
    end

    assign queued = st_q.queued;
    assign prio   = prio_q;
    assign server = server_q;

    // R3
    mask_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_level && trig && !cfg_hit && !prio_live(prio_q)) |=> st_q.mpend);

    // R4
    sent_queue_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.sent) |-> st_q.queued);

    // R5
    rej_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (!is_level && rej_hit && !scan_hit) |=> st_q.rejected);

    // R6
    eoi_level_chk: assert property (@(posedge clk) disable iff (rst)
        (is_level && eoi_hit && !cfg_hit && !scan_hit && !lvl_change) |=> !st_q.sent);

endmodule

// File: rtl/irqsrc_arbiter.sv
module irqsrc_arbiter #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req,
    input  logic               ready,
    output logic               valid,
    output logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] grant
);

    localparam logic [NUM_SRC-1:0] ONE = {{(NUM_SRC-1){1'b0}}, 1'b1};

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                valid = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    assign grant = (valid && ready) ? (ONE << idx) : '0;

    // R8
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R8
    grant_req_chk: assert property (@(posedge clk) disable iff (rst)
        (|grant) |-> ((grant & req) == grant));

endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic [NUM_SRC-1:0] visit
);

    localparam logic [IDX_W-1:0]   LAST = IDX_W'(NUM_SRC - 1);
    localparam logic [NUM_SRC-1:0] ONE  = {{(NUM_SRC-1){1'b0}}, 1'b1};

    logic             busy_q;
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ptr_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                ptr_q  <= '0;
            end
        end else if (ptr_q == LAST) begin
            busy_q <= 1'b0;
        end else begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign busy  = busy_q;
    assign visit = busy_q ? (ONE << ptr_q) : '0;

    // R7
    scan_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_q) |-> ($past(ptr_q) == LAST));

    // R7
    scan_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && ptr_q != LAST) |=> (busy_q && ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/irq_source_unit.sv
module irq_source_unit
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int SRC_BASE = 4096,
    parameter int SRCNUM_W = 16,
    parameter int SERVER_W = 4,
    localparam int IDX_W = $clog2(NUM_SRC)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_level,
    input  logic [NUM_SRC-1:0]  trig_in,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [SERVER_W-1:0] cfg_server,
    input  logic [7:0]          cfg_prio,
    input  logic                rej_valid,
    input  logic [SRCNUM_W-1:0] rej_num,
    input  logic                eoi_valid,
    input  logic [SRCNUM_W-1:0] eoi_num,
    input  logic                resend_req,
    output logic                resend_busy,
    output logic                offer_valid,
    input  logic                offer_ready,
    output logic [SRCNUM_W-1:0] offer_num,
    output logic [7:0]          offer_prio,
    output logic [SERVER_W-1:0] offer_server
);

    localparam logic [SRCNUM_W-1:0] BASE_N = SRCNUM_W'(SRC_BASE);
    localparam logic [SRCNUM_W-1:0] CNT_N  = SRCNUM_W'(NUM_SRC);

    logic [SRCNUM_W-1:0] rej_off, eoi_off;
    logic                rej_ok, eoi_ok;
    logic [NUM_SRC-1:0]  queued_v, grant_v, visit_v;
    prio_t               prio_v   [NUM_SRC];
    logic [SERVER_W-1:0] server_v [NUM_SRC];
    logic [IDX_W-1:0]    sel_idx;

    assign rej_off = rej_num - BASE_N;
    assign eoi_off = eoi_num - BASE_N;
    assign rej_ok  = rej_valid && (rej_num >= BASE_N) && (rej_off < CNT_N);
    assign eoi_ok  = eoi_valid && (eoi_num >= BASE_N) && (eoi_off < CNT_N);

    irqsrc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk   (clk),
        .rst   (rst),
        .start (resend_req),
        .busy  (resend_busy),
        .visit (visit_v)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irqsrc_slot #(.SERVER_W(SERVER_W)) u_slot (
            .clk        (clk),
            .rst        (rst),
            .is_level   (src_level[i]),
            .trig       (trig_in[i]),
            .cfg_hit    (cfg_we && (cfg_idx == IDX_W'(i))),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .rej_hit    (rej_ok && (rej_off == SRCNUM_W'(i))),
            .eoi_hit    (eoi_ok && (eoi_off == SRCNUM_W'(i))),
            .scan_hit   (visit_v[i]),
            .grant      (grant_v[i]),
            .queued     (queued_v[i]),
            .prio       (prio_v[i]),
            .server     (server_v[i])
        );
    end

    irqsrc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk   (clk),
        .rst   (rst),
        .req   (queued_v),
        .ready (offer_ready),
        .valid (offer_valid),
        .idx   (sel_idx),
        .grant (grant_v)
    );

    assign offer_num    = BASE_N + SRCNUM_W'(sel_idx);
    assign offer_prio   = prio_v[sel_idx];
    assign offer_server = server_v[sel_idx];

    // R8
    offer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (offer_valid && !offer_ready) |=> offer_valid);

    // R9
    offer_range_chk: assert property (@(posedge clk) disable iff (rst)
        offer_valid |-> (offer_num >= BASE_N && offer_num < BASE_N + CNT_N));

endmodule

// File: tb/irq_source_unit_test.sv
module irq_source_unit_test;

    localparam int N    = 16;
    localparam int BASE = 4096;
    localparam logic [N-1:0] LVL = 16'hFF00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] trig_in = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [3:0]  cfg_server = '0;
    logic [7:0]  cfg_prio = '0;
    logic        rej_valid = 1'b0;
    logic [15:0] rej_num = '0;
    logic        eoi_valid = 1'b0;
    logic [15:0] eoi_num = '0;
    logic        resend_req = 1'b0;
    logic        offer_ready = 1'b0;
    logic        resend_busy, offer_valid;
    logic [15:0] offer_num;
    logic [7:0]  offer_prio;
    logic [3:0]  offer_server;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";

    // reference model state
    int m_prio [N];
    int m_srv  [N];
    bit m_as [N], m_sent [N], m_rej [N], m_mp [N], m_q [N];
    bit m_busy;
    int m_ptr;

    irq_source_unit uut (
        .clk(clk), .rst(rst), .src_level(LVL), .trig_in(trig_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
        .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
        .resend_req(resend_req), .resend_busy(resend_busy), .offer_valid(offer_valid),
        .offer_ready(offer_ready), .offer_num(offer_num), .offer_prio(offer_prio),
        .offer_server(offer_server)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin : model
        int g, sv, rv, ev;
        bit cw, chg;
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected below 100000", cycles);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_prio[i] = 255; m_srv[i] = 0;
                m_as[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_q[i] = 0;
            end
            m_busy = 0; m_ptr = 0;
        end else begin
            g = -1;
            for (int i = 0; i < N; i++) if (m_q[i] && g < 0) g = i;
            if (g >= 0 && offer_ready) m_q[g] = 0;
            sv = m_busy ? m_ptr : -1;
            if (m_busy) begin
                if (m_ptr == N - 1) m_busy = 0; else m_ptr++;
            end else if (resend_req) begin
                m_busy = 1; m_ptr = 0;
            end
            rv = (rej_valid && rej_num >= BASE && rej_num < BASE + N) ? int'(rej_num) - BASE : -1;
            ev = (eoi_valid && eoi_num >= BASE && eoi_num < BASE + N) ? int'(eoi_num) - BASE : -1;
            for (int i = 0; i < N; i++) begin
                cw = cfg_we && (int'(cfg_idx) == i);
                if (LVL[i]) begin
                    chg = trig_in[i] != m_as[i];
                    m_as[i] = trig_in[i];
                    if (rv == i) m_sent[i] = 0;
                    if (ev == i) m_sent[i] = 0;
                    if (cw) begin m_prio[i] = cfg_prio; m_srv[i] = cfg_server; end
                    if ((cw || sv == i || chg) && m_prio[i] != 255 && m_as[i] && !m_sent[i]) begin
                        m_sent[i] = 1; m_q[i] = 1;
                    end
                end else begin
                    if (rv == i) m_rej[i] = 1;
                    if (cw) begin m_prio[i] = cfg_prio; m_srv[i] = cfg_server; end
                    if (trig_in[i]) begin
                        if (m_prio[i] != 255) m_q[i] = 1; else m_mp[i] = 1;
                    end
                    if (cw && m_mp[i] && m_prio[i] != 255) begin m_mp[i] = 0; m_q[i] = 1; end
                    if (sv == i && m_rej[i]) begin
                        m_rej[i] = 0;
                        if (m_prio[i] != 255) m_q[i] = 1;
                    end
                end
            end
        end
    end

    task automatic compare();
        int e, ee;
        e = -1;
        for (int i = 0; i < N; i++) if (m_q[i] && e < 0) e = i;
        ee = (e < 0) ? 0 : e;
        checks++;
        if (offer_valid !== (e >= 0) || resend_busy !== m_busy ||
            (e >= 0 && (offer_num !== 16'(BASE + e) || offer_prio !== 8'(m_prio[ee]) ||
                        offer_server !== 4'(m_srv[ee])))) begin
            fails++;
            $display("FAIL %s: valid=%0b num=%0h prio=%0h srv=%0d busy=%0b expected valid=%0b num=%0h prio=%0h srv=%0d busy=%0b",
                     cur_req, offer_valid, offer_num, offer_prio, offer_server, resend_busy,
                     (e >= 0), BASE + ee, m_prio[ee], m_srv[ee], m_busy);
        end
    endtask

    task automatic cyc(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            cfg_we = 0; rej_valid = 0; eoi_valid = 0; resend_req = 0;
            trig_in = trig_in & LVL;
        end
    endtask

    task automatic direct(string req, bit exp_v, int exp_num, int exp_prio);
        checks++;
        if (offer_valid !== exp_v || (exp_v && (offer_num !== 16'(exp_num) || offer_prio !== 8'(exp_prio)))) begin
            fails++;
            $display("FAIL %s: valid=%0b num=%0h prio=%0h expected valid=%0b num=%0h prio=%0h",
                     req, offer_valid, offer_num, offer_prio, exp_v, exp_num, exp_prio);
        end
    endtask

    task automatic cfg(int idx, int srv, int pr);
        cfg_we = 1; cfg_idx = 4'(idx); cfg_server = 4'(srv); cfg_prio = 8'(pr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        cur_req = "R1";
        cyc(2);
        direct("R1", 0, 0, 0);

        cur_req = "R2";
        offer_ready = 1;
        cfg(2, 3, 5); cyc(1);
        trig_in[2] = 1; cyc(1);
        direct("R2", 1, BASE + 2, 5);
        cyc(2);

        cur_req = "R8";
        offer_ready = 0;
        cfg(4, 1, 9); cyc(1);
        trig_in[4] = 1; trig_in[2] = 1; cyc(1);
        direct("R8", 1, BASE + 2, 5);
        cyc(3);
        offer_ready = 1; cyc(1);
        direct("R8", 1, BASE + 4, 9);
        cyc(2);

        cur_req = "R3";
        trig_in[6] = 1; cyc(1);
        direct("R3", 0, 0, 0);
        cyc(2);
        cfg(6, 2, 7); cyc(1);
        direct("R3", 1, BASE + 6, 7);
        cyc(2);

        cur_req = "R4";
        cfg(9, 5, 3); cyc(1);
        trig_in[9] = 1; cyc(1);
        direct("R4", 1, BASE + 9, 3);
        cyc(4);
        direct("R4", 0, 0, 0);

        cur_req = "R5";
        rej_valid = 1; rej_num = 16'(BASE + 9); cyc(1);
        rej_valid = 1; rej_num = 16'(BASE + 2); cyc(1);
        cyc(3);
        direct("R5", 0, 0, 0);

        cur_req = "R7";
        resend_req = 1; cyc(1);
        resend_req = 1; cyc(N + 4);
        direct("R7", 0, 0, 0);

        cur_req = "R6";
        eoi_valid = 1; eoi_num = 16'(BASE + 2); cyc(2);
        eoi_valid = 1; eoi_num = 16'(BASE + 9); cyc(2);
        direct("R6", 0, 0, 0);
        resend_req = 1; cyc(N + 2);

        cur_req = "R9";
        rej_valid = 1; rej_num = 16'(BASE + N + 9); cyc(1);
        eoi_valid = 1; eoi_num = 16'(BASE - 7); cyc(1);
        resend_req = 1; cyc(N + 2);
        direct("R9", 0, 0, 0);

        cur_req = "R8";
        for (int t = 0; t < 3000; t++) begin
            logic [31:0] r;
            r = $urandom;
            offer_ready = r[0] | r[1];
            if (r[7:2] == 0) trig_in = trig_in ^ (LVL & (N'(1) << r[11:8]));
            if (r[15:12] == 0) trig_in = trig_in | (~LVL & (N'(1) << r[19:16]));
            if (r[22:20] == 0) cfg(int'(r[26:23]), int'(r[30:27]), (r[31] ? 255 : int'(r[13:10])));
            if (r[9:6] == 1) begin rej_valid = 1; rej_num = 16'(BASE + int'(r[20:16]) - 4); end
            if (r[9:6] == 2) begin eoi_valid = 1; eoi_num = 16'(BASE + int'(r[20:16]) - 4); end
            if (r[11:4] == 3) resend_req = 1;
            cyc(1);
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule